// File: doc/BRIEF.md
# Three-Channel DMA Transfer Controller

This block moves data between memory locations on its own. It has three channels. Software sets up each channel through a write-only register bus, giving it a source pointer, a destination pointer, a transfer count and a control word. After that, a trigger makes the channel copy data. A trigger can be one of up to fifteen hardware request lines or a software request bit. Each element is copied as a read cycle followed by a write cycle on a simple memory port. The memory port answers in the same cycle. Each side of the copy can be a byte or a word, and each pointer can hold, count up or count down.

A channel can copy one element per trigger, a whole block per trigger, or a block broken into bursts. Each of these three modes has a repeating variant, in which the pointers and count reload after each block. Two shared registers control all channels:
- a trigger-select register, with one field per channel;
- an option register, with three options: rotating channel priority, abort on a non-maskable event, and starting only on an instruction-fetch strobe.

Top module: `dmac_top`

## Requirements
- R1: After synchronous reset, no memory cycle is issued, `irq` is low, every channel is disabled and every trigger select is 0.
- R2: Each element is one read cycle (`mem_we`=0) followed in the next cycle by one write cycle (`mem_we`=1). Byte-wide access is flagged on `mem_byte`.
  - A byte read (control bit 6) is zero-extended.
  - A byte write (control bit 7) carries only the low 8 bits of the value, with the upper bits zero.
- R3: The source step code sits in control bits 11:10 and the destination step code in bits 9:8. Code 00 holds the pointer, 10 decrements it and 11 increments it. The step is 1 for a byte side and 2 for a word side.
- R4: In single mode (control bits 14:12 = 000), each trigger copies one element. When the count reaches zero, the enable bit (bit 4) clears, and later triggers copy nothing.
- R5: In block mode (001), one trigger copies the whole count with read and write cycles back to back, with no idle cycle.
- R6: In burst mode (010), one trigger copies the whole count. Exactly one idle cycle is inserted after every four elements, except after the last element.
- R7: Codes 100, 101 and 110 repeat single, block and burst mode. At the end of the count, the pointers and count reload from their programmed values and the channel stays enabled.
- R8: The done flag (control bit 3) sets when a channel's count reaches zero. `irq` is high while any channel has both its done flag and its interrupt-enable bit (bit 2) set.
- R9: With rotation off (option bit 0 = 0), pending channels are served in the order 0, 1, 2. With rotation on, the channel served last becomes the lowest priority after each element.
- R10: When the abort option (option bit 1) is on, a pulse on `nmi` during a transfer has this effect:
  - the element in progress completes;
  - no further element is copied;
  - the channel's enable bit clears and its abort bit (bit 1) sets.

  When the abort option is off, `nmi` has no effect.
- R11: Trigger selects are 4-bit fields at bits 4c+3:4c of register 0, one per channel c. A write to register 0 leaves unchanged the field of any channel whose enable bit is set.
- R12: Level sensitivity is set by control bit 5. With bit 5 = 0, the selected line triggers only on a rising edge. With bit 5 = 1, it triggers on every cycle the line is high.
- R13: Trigger select 0 means software request. Writing control bit 0 as 1 on an enabled channel starts it, and the bit clears once the request is taken.
- R14: When the fetch option (option bit 2) is on, a pending channel starts only in a cycle where `fetch_stb` is high.

Register map: register 0 holds the trigger selects and register 1 holds the options. Each channel c has four registers at 4+4c: control, then source, destination and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register index |
| wr_data | input | 16 | Register write value |
| trig_in | input | 16 | Hardware request lines, selected by index (line 0 unused) |
| fetch_stb | input | 1 | Instruction-fetch strobe for deferred start |
| nmi | input | 1 | Non-maskable event pulse |
| mem_req | output | 1 | Memory cycle active |
| mem_we | output | 1 | Memory cycle is a write |
| mem_byte | output | 1 | Memory cycle is byte-wide |
| mem_addr | output | 16 | Byte address of the cycle |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in the read cycle |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: three channels, 4-bit trigger selects and bursts of four. With three channels, a rotation order (2, 0, 1) can be told apart from the fixed order (0, 1, 2) within a single trigger event. A burst length of four lets an 8-element burst show exactly one bus gap. The random cases draw the step codes, the byte or word width of each side, and counts from 1 to 6. Word pointers start even, so every step stays within a 256-byte model memory.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int ADDR_W = 16;
    localparam int CTL_W  = 15;

    // Copy style in mode bits [1:0]; bit [2] selects the repeating variant
    typedef enum logic [1:0] {
        KIND_SINGLE = 2'b00,
        KIND_BLOCK  = 2'b01,
        KIND_BURST  = 2'b10
    } kind_e;

    localparam logic [1:0] STEP_DEC = 2'b10;
    localparam logic [1:0] STEP_INC = 2'b11;

    typedef struct packed {
        logic [2:0] mode;      // 14:12
        logic [1:0] src_step;  // 11:10
        logic [1:0] dst_step;  // 9:8
        logic       dst_byte;  // 7
        logic       src_byte;  // 6
        logic       level;     // 5
        logic       en;        // 4
        logic       done;      // 3
        logic       ie;        // 2
        logic       abort;     // 1
        logic       req;       // 0
    } ctl_t;

    typedef struct packed {
        logic defer;   // 2
        logic nmi_en;  // 1
        logic rotate;  // 0
    } opt_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_RD,
        S_WR,
        S_GAP
    } eng_e;

    function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                    input logic [1:0] code,
                                                    input logic is_byte);
        logic [ADDR_W-1:0] d;
        d = is_byte ? ADDR_W'(1) : ADDR_W'(2);
        case (code)
            STEP_INC: return a + d;
            STEP_DEC: return a - d;
            default:  return a;
        endcase
    endfunction

endpackage

// File: rtl/dmac_trig.sv
module dmac_trig #(
    parameter int SEL_W = 4,
    localparam int LINES = 2 ** SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] trig_in,
    input  logic [SEL_W-1:0] sel,
    input  logic             level,
    input  logic             en,
    input  logic             sw_req,
    output logic             evt
);
    logic line_now;
    logic line_prev;

    assign line_now = trig_in[sel];

    always_ff @(posedge clk) begin
        if (rst) line_prev <= 1'b0;
        else     line_prev <= line_now;
    end

    always_comb begin
        if (!en)                evt = 1'b0;
        else if (sel == '0)     evt = sw_req;
        else if (level)         evt = line_now;
        else                    evt = line_now & ~line_prev;
    end
endmodule

// File: rtl/dmac_arb.sv
module dmac_arb #(
    parameter int N = 3,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic          rotate,
    input  logic [IW-1:0] last,
    output logic          gnt_valid,
    output logic [IW-1:0] gnt_idx
);
    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int k = 0; k < N; k++) begin
            int c;
            c = rotate ? ((int'(last) + 1 + k) % N) : k;
            if (!gnt_valid && req[c]) begin
                gnt_valid = 1'b1;
                gnt_idx   = IW'(c);
            end
        end
    end
endmodule

// File: rtl/dmac_top.sv
module dmac_top
    import dmac_pkg::*;
#(
    parameter int NCH       = 3,
    parameter int TSEL_W    = 4,
    parameter int BURST_LEN = 4,
    localparam int RA_W     = $clog2(4 * (NCH + 1)),
    localparam int TW       = 2 ** TSEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [RA_W-1:0]   wr_addr,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [TW-1:0]     trig_in,
    input  logic              fetch_stb,
    input  logic              nmi,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_byte,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              irq
);
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int BW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam int GW = RA_W - 2;

    ctl_t              ctl   [NCH];
    logic [ADDR_W-1:0] src_p [NCH];
    logic [ADDR_W-1:0] dst_p [NCH];
    logic [ADDR_W-1:0] siz_p [NCH];
    logic [ADDR_W-1:0] src_w [NCH];
    logic [ADDR_W-1:0] dst_w [NCH];
    logic [ADDR_W-1:0] cnt_w [NCH];
    logic [TSEL_W-1:0] tsel  [NCH];
    opt_t              opt;
    logic [NCH-1:0]    pend, evt, arb_req;
    eng_e              st;
    logic [IW-1:0]     cur, last, gnt_idx, wch;
    logic              gnt_valid;
    logic [BW-1:0]     bcnt;
    logic [ADDR_W-1:0] dat, src_nx, dst_nx, cnt_nx;
    logic              nmi_pend, nmi_hit, rep;
    kind_e             kind;
    logic [GW-1:0]     grp;
    logic              unused_wr_bits;

    assign unused_wr_bits = ^wr_data[ADDR_W-1:CTL_W];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dmac_trig #(.SEL_W(TSEL_W)) u_trig (
            .clk    (clk),
            .rst    (rst),
            .trig_in(trig_in),
            .sel    (tsel[c]),
            .level  (ctl[c].level),
            .en     (ctl[c].en),
            .sw_req (ctl[c].req),
            .evt    (evt[c])
        );
        assign arb_req[c] = pend[c] & ctl[c].en & ~ctl[c].abort;
    end

    dmac_arb #(.N(NCH)) u_arb (
        .req      (arb_req),
        .rotate   (opt.rotate),
        .last     (last),
        .gnt_valid(gnt_valid),
        .gnt_idx  (gnt_idx)
    );

    assign grp     = wr_addr[RA_W-1:2];
    assign wch     = IW'(int'(grp) - 1);
    assign kind    = kind_e'(ctl[cur].mode[1:0]);
    assign rep     = ctl[cur].mode[2];
    assign nmi_hit = opt.nmi_en & (nmi | nmi_pend);
    assign src_nx  = step_addr(src_w[cur], ctl[cur].src_step, ctl[cur].src_byte);
    assign dst_nx  = step_addr(dst_w[cur], ctl[cur].dst_step, ctl[cur].dst_byte);
    assign cnt_nx  = cnt_w[cur] - ADDR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NCH; c++) begin
                ctl[c]   <= '0;
                src_p[c] <= '0;
                dst_p[c] <= '0;
                siz_p[c] <= '0;
                src_w[c] <= '0;
                dst_w[c] <= '0;
                cnt_w[c] <= '0;
                tsel[c]  <= '0;
            end
            opt      <= '0;
            pend     <= '0;
            st       <= S_IDLE;
            cur      <= '0;
            last     <= IW'(NCH - 1);
            bcnt     <= '0;
            dat      <= '0;
            nmi_pend <= 1'b0;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                pend[c] <= (pend[c] | evt[c]) & ctl[c].en;
                if (ctl[c].req && ctl[c].en && tsel[c] == '0) ctl[c].req <= 1'b0;
            end
            if (opt.nmi_en && nmi && st != S_IDLE) nmi_pend <= 1'b1;

            case (st)
                S_IDLE: begin
                    nmi_pend <= 1'b0;
                    if (gnt_valid && (!opt.defer || fetch_stb)) begin
                        cur           <= gnt_idx;
                        pend[gnt_idx] <= 1'b0;
                        bcnt          <= '0;
                        st            <= S_RD;
                    end
                end
                S_RD: begin
                    dat <= ctl[cur].src_byte ? {{(ADDR_W-8){1'b0}}, mem_rdata[7:0]} : mem_rdata;
                    st  <= S_WR;
                end
                S_WR: begin
                    src_w[cur] <= src_nx;
                    dst_w[cur] <= dst_nx;
                    cnt_w[cur] <= cnt_nx;
                    last       <= cur;
                    if (nmi_hit) begin
                        ctl[cur].en    <= 1'b0;
                        ctl[cur].abort <= 1'b1;
                        pend[cur]      <= 1'b0;
                        nmi_pend       <= 1'b0;
                        st             <= S_IDLE;
                    end else if (cnt_nx == '0) begin
                        ctl[cur].done <= 1'b1;
                        if (rep) begin
                            src_w[cur] <= src_p[cur];
                            dst_w[cur] <= dst_p[cur];
                            cnt_w[cur] <= siz_p[cur];
                        end else begin
                            ctl[cur].en <= 1'b0;
                        end
                        st <= S_IDLE;
                    end else begin
                        case (kind)
                            KIND_BLOCK: st <= S_RD;
                            KIND_BURST: begin
                                if (bcnt == BW'(BURST_LEN - 1)) begin
                                    bcnt <= '0;
                                    st   <= S_GAP;
                                end else begin
                                    bcnt <= bcnt + BW'(1);
                                    st   <= S_RD;
                                end
                            end
                            default: st <= S_IDLE;
                        endcase
                    end
                end
                default: st <= S_RD;
            endcase

            if (wr_en) begin
                if (grp == '0) begin
                    if (wr_addr[1:0] == 2'd0) begin
                        for (int c = 0; c < NCH; c++)
                            if (!ctl[c].en) tsel[c] <= wr_data[c*TSEL_W +: TSEL_W];
                    end else if (wr_addr[1:0] == 2'd1) begin
                        opt <= opt_t'(wr_data[2:0]);
                    end
                end else if (int'(grp) <= NCH) begin
                    case (wr_addr[1:0])
                        2'd0: begin
                            ctl[wch] <= ctl_t'(wr_data[CTL_W-1:0]);
                            if (wr_data[4] && !ctl[wch].en) begin
                                src_w[wch] <= src_p[wch];
                                dst_w[wch] <= dst_p[wch];
                                cnt_w[wch] <= siz_p[wch];
                            end
                        end
                        2'd1:    src_p[wch] <= wr_data;
                        2'd2:    dst_p[wch] <= wr_data;
                        default: siz_p[wch] <= wr_data;
                    endcase
                end
            end
        end
    end

    assign mem_req   = (st == S_RD) || (st == S_WR);
    assign mem_we    = (st == S_WR);
    assign mem_byte  = mem_req && (mem_we ? ctl[cur].dst_byte : ctl[cur].src_byte);
    assign mem_addr  = !mem_req ? '0 : (mem_we ? dst_w[cur] : src_w[cur]);
    assign mem_wdata = ctl[cur].dst_byte ? {{(ADDR_W-8){1'b0}}, dat[7:0]} : dat;

    always_comb begin
        irq = 1'b0;
        for (int c = 0; c < NCH; c++) irq = irq | (ctl[c].done & ctl[c].ie);
    end
endmodule

// File: rtl/dmac_chk.sv
module dmac_chk (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic mem_req,
    input logic mem_we,
    input logic irq
);
    // R1: the first cycle out of reset carries no memory cycle
    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !mem_req);

    // R2: every write cycle is directly preceded by a read cycle
    p_rd_before_wr_r2: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(mem_req && !mem_we));

    // R2: every read cycle is directly followed by a write cycle
    p_wr_after_rd_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |=> mem_we);

    // R8: irq rises only after a completed write or a register write
    p_irq_rise_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(mem_we || wr_en));

    // R8: irq falls only after a register write
    p_irq_fall_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(wr_en));
endmodule

bind dmac_top dmac_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .mem_req(mem_req),
    .mem_we (mem_we),
    .irq    (irq)
);

// File: tb/sim_dmac_top.sv
module sim_dmac_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] trig_in = '0;
    logic        fetch_stb = 1'b0;
    logic        nmi = 1'b0;
    logic        mem_req, mem_we, mem_byte, irq;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;

    logic [7:0]  mem [256];
    int          nchk = 0, nfail = 0, cyc = 0;
    bit          done = 0, clr = 0;
    int          wn, nreq, first_c, last_c;
    logic [15:0] wl_addr [64];
    logic [15:0] wl_data [64];

    always #4 clk = ~clk;

    dmac_top u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .trig_in(trig_in), .fetch_stb(fetch_stb), .nmi(nmi),
        .mem_req(mem_req), .mem_we(mem_we), .mem_byte(mem_byte),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq)
    );

    assign mem_rdata = mem_byte ? {8'h00, mem[mem_addr[7:0]]}
                                : {mem[{mem_addr[7:1], 1'b1}], mem[{mem_addr[7:1], 1'b0}]};

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (clr) begin
            wn <= 0; nreq <= 0; first_c <= -1; last_c <= -1;
        end else if (!rst && mem_req) begin
            nreq <= nreq + 1;
            if (first_c < 0) first_c <= cyc;
            last_c <= cyc;
            if (mem_we) begin
                if (wn < 64) begin
                    wl_addr[wn] <= mem_addr;
                    wl_data[wn] <= mem_wdata;
                end
                wn <= wn + 1;
                if (mem_byte) mem[mem_addr[7:0]] <= mem_wdata[7:0];
                else begin
                    mem[{mem_addr[7:1], 1'b0}] <= mem_wdata[7:0];
                    mem[{mem_addr[7:1], 1'b1}] <= mem_wdata[15:8];
                end
            end
        end
        if (cyc > 150000 && !done) begin
            done = 1;
            nfail = nfail + 1;
            $display("FAIL watchdog act=%0d exp=0", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    task automatic chk(input string rq, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; trig_in = '0; nmi = 1'b0; fetch_stb = 1'b0; wr_en = 1'b0;
        ticks(3);
        rst = 1'b0; clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic prog(input int ch, input int s, input int d, input int n);
        wr(5 + 4 * ch, 16'(s));
        wr(6 + 4 * ch, 16'(d));
        wr(7 + 4 * ch, 16'(n));
    endtask

    function automatic logic [15:0] mkctl(input logic [2:0] mode, input logic [1:0] ss,
                                          input logic [1:0] ds, input logic sb, input logic db,
                                          input logic lvl, input logic ie, input logic en,
                                          input logic rq);
        return {1'b0, mode, ss, ds, db, sb, lvl, en, 1'b0, ie, 1'b0, rq};
    endfunction

    function automatic logic [15:0] stepf(input logic [15:0] a, input logic [1:0] c, input logic b);
        int d = b ? 1 : 2;
        if (c == 2'b11) return a + 16'(d);
        if (c == 2'b10) return a - 16'(d);
        return a;
    endfunction

    function automatic logic [15:0] expdata(input logic [15:0] a, input logic sb, input logic db);
        logic [15:0] v;
        v = sb ? {8'h00, mem[a[7:0]]} : {mem[{a[7:1], 1'b1}], mem[{a[7:1], 1'b0}]};
        return db ? {8'h00, v[7:0]} : v;
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);

        // R1 reset state
        do_reset();
        ticks(10);
        chk("R1 no cycles after reset", nreq, 0);
        chk("R1 irq low after reset", int'(irq), 0);

        // R2 R3 R5 R13 random block copies by software request
        for (int it = 0; it < 12; it++) begin
            logic [1:0] ss, ds;
            logic sb, db;
            int n, bad;
            logic [15:0] sa, da;
            int r;
            r = $urandom_range(0, 2); ss = (r == 0) ? 2'b00 : (r == 1) ? 2'b10 : 2'b11;
            r = $urandom_range(0, 2); ds = (r == 0) ? 2'b00 : (r == 1) ? 2'b10 : 2'b11;
            sb = 1'($urandom_range(0, 1)); db = 1'($urandom_range(0, 1));
            n = $urandom_range(1, 6);
            do_reset();
            prog(0, 16'h0040, 16'h00C0, n);
            wr(4, mkctl(3'b001, ss, ds, sb, db, 0, 1, 1, 1));
            ticks(30);
            chk("R5 block element count", wn, n);
            chk("R5 block has no idle cycle", (last_c - first_c + 1) - nreq, 0);
            chk("R8 irq after block", int'(irq), 1);
            sa = 16'h0040; da = 16'h00C0; bad = 0;
            for (int k = 0; k < n && k < 64; k++) begin
                if (wl_addr[k] != da || wl_data[k] != expdata(sa, sb, db)) begin
                    if (bad == 0)
                        $display("FAIL R2/R3 elem %0d act=%h:%h exp=%h:%h", k,
                                 wl_addr[k], wl_data[k], da, expdata(sa, sb, db));
                    bad++;
                end
                sa = stepf(sa, ss, sb); da = stepf(da, ds, db);
            end
            nchk++;
            if (bad != 0) nfail++;
        end

        // R4 R8 R12 single mode, edge triggered
        do_reset();
        wr(0, 16'h0001);
        prog(0, 16'h0010, 16'h00B0, 2);
        wr(4, mkctl(3'b000, 2'b11, 2'b11, 0, 0, 0, 1, 1, 0));
        trig_in[1] = 1'b1; ticks(6); trig_in[1] = 1'b0; ticks(6);
        chk("R12 edge gives one element", wn, 1);
        chk("R8 irq low before count ends", int'(irq), 0);
        trig_in[1] = 1'b1; ticks(1); trig_in[1] = 1'b0; ticks(8);
        chk("R4 second trigger copies", wn, 2);
        chk("R8 irq at count zero", int'(irq), 1);
        trig_in[1] = 1'b1; ticks(1); trig_in[1] = 1'b0; ticks(8);
        chk("R4 disabled after count", wn, 2);

        // R12 level triggered
        do_reset();
        wr(0, 16'h0001);
        prog(0, 16'h0010, 16'h00B0, 20);
        wr(4, mkctl(3'b000, 2'b11, 2'b11, 0, 0, 1, 0, 1, 0));
        trig_in[1] = 1'b1; ticks(12); trig_in[1] = 1'b0; ticks(8);
        chk("R12 level gives several elements", int'(wn >= 2), 1);

        // R6 R8 burst with gap, interrupt disabled
        do_reset();
        prog(0, 16'h0010, 16'h00B0, 8);
        wr(4, mkctl(3'b010, 2'b11, 2'b11, 0, 0, 0, 0, 1, 1));
        ticks(40);
        chk("R6 burst element count", wn, 8);
        chk("R6 burst idle cycles", (last_c - first_c + 1) - nreq, 1);
        chk("R8 irq masked by enable", int'(irq), 0);

        // R7 repeated block reloads
        do_reset();
        prog(0, 16'h0020, 16'h00D0, 3);
        wr(4, mkctl(3'b101, 2'b11, 2'b11, 0, 0, 0, 1, 1, 1));
        ticks(20);
        chk("R7 first block", wn, 3);
        chk("R8 irq after repeat block", int'(irq), 1);
        wr(4, mkctl(3'b101, 2'b11, 2'b11, 0, 0, 0, 1, 1, 1));
        ticks(20);
        chk("R7 second block", wn, 6);
        chk("R7 reload dst start", int'(wl_addr[3]), 16'h00D0);
        chk("R7 reload dst end", int'(wl_addr[5]), 16'h00D4);

        // R9 fixed then rotating priority
        for (int rot = 0; rot < 2; rot++) begin
            int ord;
            do_reset();
            if (rot == 1) wr(1, 16'h0001);
            wr(0, 16'h0121);
            for (int c = 0; c < 3; c++) begin
                prog(c, 16'h0010, 16'h0080 + 16 * c, 4);
                wr(4 + 4 * c, mkctl(3'b000, 2'b11, 2'b11, 0, 0, 0, 0, 1, 0));
            end
            trig_in[2] = 1'b1; ticks(1); trig_in[2] = 1'b0; ticks(10);
            trig_in[2:1] = 2'b11; ticks(1); trig_in[2:1] = 2'b00; ticks(20);
            chk("R9 element count", wn, 4);
            ord = 100 * ((wl_addr[1] - 16'h80) >> 4) + 10 * ((wl_addr[2] - 16'h80) >> 4)
                + ((wl_addr[3] - 16'h80) >> 4);
            chk(rot ? "R9 rotating order" : "R9 fixed order", ord, rot ? 201 : 12);
        end

        // R10 abort on nmi
        for (int en_nmi = 1; en_nmi >= 0; en_nmi--) begin
            int w0;
            do_reset();
            if (en_nmi == 1) wr(1, 16'h0002);
            prog(0, 16'h0010, 16'h00B0, 10);
            wr(4, mkctl(3'b001, 2'b11, 2'b11, 0, 0, 0, 0, 1, 1));
            while (wn < 3) @(negedge clk);
            w0 = wn;
            nmi = 1'b1; ticks(1); nmi = 1'b0;
            ticks(40);
            if (en_nmi == 1) begin
                chk("R10 current element completes then stops", wn, w0 + 1);
                chk("R10 no half element", nreq, 2 * wn);
            end else begin
                chk("R10 nmi ignored when option off", wn, 10);
            end
        end

        // R11 trigger select locked while enabled
        do_reset();
        wr(0, 16'h0001);
        prog(0, 16'h0010, 16'h00B0, 5);
        wr(4, mkctl(3'b000, 2'b11, 2'b11, 0, 0, 0, 0, 1, 0));
        wr(0, 16'h0002);
        trig_in[2] = 1'b1; ticks(1); trig_in[2] = 1'b0; ticks(10);
        chk("R11 locked select ignores new line", wn, 0);
        trig_in[1] = 1'b1; ticks(1); trig_in[1] = 1'b0; ticks(10);
        chk("R11 old line still active", wn, 1);
        wr(4, mkctl(3'b000, 2'b11, 2'b11, 0, 0, 0, 0, 0, 0));
        wr(0, 16'h0002);
        wr(4, mkctl(3'b000, 2'b11, 2'b11, 0, 0, 0, 0, 1, 0));
        trig_in[2] = 1'b1; ticks(1); trig_in[2] = 1'b0; ticks(10);
        chk("R11 select changes when disabled", wn, 2);

        // R14 deferred start
        do_reset();
        wr(1, 16'h0004);
        prog(0, 16'h0010, 16'h00B0, 3);
        wr(4, mkctl(3'b001, 2'b11, 2'b11, 0, 0, 0, 0, 1, 1));
        ticks(12);
        chk("R14 waits for fetch strobe", wn, 0);
        fetch_stb = 1'b1; ticks(1); fetch_stb = 1'b0; ticks(20);
        chk("R14 block after strobe", wn, 3);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule